// File: doc/BRIEF.md
# Clock Output Stop Controller

This block sits between a clock synthesizer and the output pins of a system clock generator. It takes the already generated source clocks (a CPU clock, a PCI clock, a 66 MHz clock, a 48 MHz clock and a reference clock). From them it produces the gated per-pin outputs: one CPU true/complement pair, seven PCI outputs, three normally free-running PCI outputs, a group of 66 MHz outputs, a group of 48 MHz outputs and one reference output.

Each output lane carries its own stop request into its own clock domain through a two-flop synchronizer. A small falling-edge state machine (states HELD and RUN) then opens or closes the gate. An output therefore only ever stops or restarts while its source is low, and no short pulse can appear. Three things can close a lane's gate: a PCI stop request (from the active-low pin or from a software run bit), a qualified power-down, or the lane's own enable bit being 0.

Power-down is qualified in the CPU clock domain by a three-state machine: AWAKE, ARMED and DOWN. AWAKE moves to ARMED on a low sample of the power-down pin. ARMED moves to DOWN on a second consecutive low sample, or falls back to AWAKE on a high sample. DOWN returns to AWAKE on the first high sample. While in DOWN, the CPU true output is parked high, the complement is held low and its float indication is raised.

Top module: `ckstop_ctrl`

## Requirements
- R1: The PCI stop condition is active when `pci_stop_n_i` is 0 or `sw_pci_run_i` is 0; with both at 1 the PCI outputs run.
- R2: Under PCI stop, every enabled PCI output (`pci_o`) finishes its current high phase, then stays low.
- R3: Each output of `pcif_o` keeps running under PCI stop while its bit in `stop_pcif_i` is 0. It stops low together with the PCI group when that bit is 1.
- R4: Power-down starts only after `pd_n_i` reads 0 at two consecutive rising edges of `clk_cpu_i`. A low level seen at a single rising edge changes no output.
- R5: While powered down, all outputs other than the CPU pair are held low.
- R6: While powered down, `cpu_t_o` is 1, `cpu_c_o` is 0 and `cpu_c_float_o` is 1. Otherwise `cpu_c_float_o` is 0.
- R7: An output whose enable bit is 0 is held low. For the CPU pair, `en_cpu_i` = 0 holds both `cpu_t_o` and `cpu_c_o` low.
- R8: When its stop cause goes away, an output restarts with a full high phase. No output ever shows a high pulse shorter than half of its source period. Power-down ends on the first rising CPU edge at which `pd_n_i` reads 1.
- R9: While `rst_n` is 0, every clock output is low and `cpu_c_float_o` is 0.
- R10: The reference output also ends a power-down stop low, even though its slow clock needs several of its own cycles to take the request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_cpu_i | input | 1 | CPU source clock, also qualifies power-down |
| clk_pci_i | input | 1 | PCI source clock |
| clk_66_i | input | 1 | 66 MHz source clock |
| clk_48_i | input | 1 | 48 MHz source clock |
| clk_ref_i | input | 1 | Reference source clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pci_stop_n_i | input | 1 | PCI stop pin, active low |
| pd_n_i | input | 1 | Power-down pin, active low |
| sw_pci_run_i | input | 1 | Software PCI run bit, 0 requests stop |
| en_cpu_i | input | 1 | CPU pair enable |
| en_pci_i | input | N_PCI | PCI output enables |
| en_pcif_i | input | N_PCIF | Free-running PCI output enables |
| stop_pcif_i | input | N_PCIF | 1 lets PCI stop halt that free-running output |
| en_66_i | input | N_66 | 66 MHz output enables |
| en_48_i | input | N_48 | 48 MHz output enables |
| en_ref_i | input | 1 | Reference output enable |
| cpu_t_o | output | 1 | CPU true output |
| cpu_c_o | output | 1 | CPU complement output |
| cpu_c_float_o | output | 1 | 1 when the complement output is to float |
| pci_o | output | N_PCI | Gated PCI outputs |
| pcif_o | output | N_PCIF | Gated free-running PCI outputs |
| m66_o | output | N_66 | Gated 66 MHz outputs |
| m48_o | output | N_48 | Gated 48 MHz outputs |
| ref_o | output | 1 | Gated reference output |

## Verification
The bench builds the block with its defaults: seven PCI lanes, three free-running PCI lanes, four 66 MHz lanes, two 48 MHz lanes and a two-stage synchronizer. With these values, mixed stoppable masks (101) can be tried against one shared stop request, and single lanes in every group can be disabled while their neighbours keep running. The reference clock is roughly nine times slower than the CPU clock, so a two-stage synchronizer makes the power-down stop take several reference cycles. A single-edge power-down pulse is aligned so that exactly one CPU rising edge sees it, which tests the ARMED-to-AWAKE fallback. A pulse-width monitor runs on all nineteen outputs throughout.

// File: rtl/ckstop_pkg.sv
`timescale 1ns/1ps
package ckstop_pkg;
    typedef enum logic {
        LN_HELD = 1'b0,
        LN_RUN  = 1'b1
    } lane_st_e;

    typedef enum logic [1:0] {
        PD_AWAKE = 2'd0,
        PD_ARMED = 2'd1,
        PD_DOWN  = 2'd2
    } pd_st_e;
endpackage

// File: rtl/ckstop_lane.sv
`timescale 1ns/1ps
module ckstop_lane
    import ckstop_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk_src_i,
    input  logic rst_n_i,
    input  logic stop_req_i,
    output logic clk_o
);
    logic [SYNC_STAGES-1:0] sync_q;
    logic                   stop_sync;
    lane_st_e               st_q;
    lane_st_e               st_d;

    // request enters the source domain on rising edges; reset means stopped
    always_ff @(posedge clk_src_i or negedge rst_n_i) begin
        if (!rst_n_i) sync_q <= '1;
        else          sync_q <= {sync_q[SYNC_STAGES-2:0], stop_req_i};
    end
    assign stop_sync = sync_q[SYNC_STAGES-1];

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            LN_RUN:  if (stop_sync)  st_d = LN_HELD;
            LN_HELD: if (!stop_sync) st_d = LN_RUN;
        endcase
    end

    // gate state only moves while the source clock is low
    always_ff @(negedge clk_src_i or negedge rst_n_i) begin
        if (!rst_n_i) st_q <= LN_HELD;
        else          st_q <= st_d;
    end

    always_comb clk_o = clk_src_i & (st_q == LN_RUN);

    // R2
    lane_stop_chk: assert property (@(negedge clk_src_i) disable iff (!rst_n_i)
        stop_sync |=> !clk_o);
    // R8
    lane_resume_chk: assert property (@(negedge clk_src_i) disable iff (!rst_n_i)
        !stop_sync |=> clk_o);
endmodule

// File: rtl/ckstop_pd_qual.sv
`timescale 1ns/1ps
module ckstop_pd_qual
    import ckstop_pkg::*;
(
    input  logic clk_i,
    input  logic rst_n_i,
    input  logic pd_n_i,
    output logic park_o
);
    pd_st_e st_q;
    pd_st_e st_d;

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            PD_AWAKE: if (!pd_n_i) st_d = PD_ARMED;
            PD_ARMED: st_d = pd_n_i ? PD_AWAKE : PD_DOWN;
            PD_DOWN:  if (pd_n_i)  st_d = PD_AWAKE;
            default:  st_d = PD_AWAKE;
        endcase
    end

    always_ff @(posedge clk_i or negedge rst_n_i) begin
        if (!rst_n_i) st_q <= PD_AWAKE;
        else          st_q <= st_d;
    end

    always_comb park_o = (st_q == PD_DOWN);

    // R4
    pd_enter_chk: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        (st_q == PD_ARMED && !pd_n_i) |=> park_o);
    // R4
    pd_single_chk: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        (st_q == PD_AWAKE) |=> !park_o);
    // R8
    pd_exit_chk: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        pd_n_i |=> !park_o);
endmodule

// File: rtl/ckstop_ctrl.sv
`timescale 1ns/1ps
module ckstop_ctrl #(
    parameter int N_PCI       = 7,
    parameter int N_PCIF      = 3,
    parameter int N_66        = 4,
    parameter int N_48        = 2,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk_cpu_i,
    input  logic              clk_pci_i,
    input  logic              clk_66_i,
    input  logic              clk_48_i,
    input  logic              clk_ref_i,
    input  logic              rst_n,
    input  logic              pci_stop_n_i,
    input  logic              pd_n_i,
    input  logic              sw_pci_run_i,
    input  logic              en_cpu_i,
    input  logic [N_PCI-1:0]  en_pci_i,
    input  logic [N_PCIF-1:0] en_pcif_i,
    input  logic [N_PCIF-1:0] stop_pcif_i,
    input  logic [N_66-1:0]   en_66_i,
    input  logic [N_48-1:0]   en_48_i,
    input  logic              en_ref_i,
    output logic              cpu_t_o,
    output logic              cpu_c_o,
    output logic              cpu_c_float_o,
    output logic [N_PCI-1:0]  pci_o,
    output logic [N_PCIF-1:0] pcif_o,
    output logic [N_66-1:0]   m66_o,
    output logic [N_48-1:0]   m48_o,
    output logic              ref_o
);
    logic pd_park;
    logic pci_stop_act;
    logic clk_cpu_n;
    logic cpu_t_lane;
    logic cpu_c_lane;

    assign pci_stop_act = ~pci_stop_n_i | ~sw_pci_run_i;
    assign clk_cpu_n    = ~clk_cpu_i;

    ckstop_pd_qual u_pd (
        .clk_i   (clk_cpu_i),
        .rst_n_i (rst_n),
        .pd_n_i  (pd_n_i),
        .park_o  (pd_park)
    );

    ckstop_lane #(.SYNC_STAGES(SYNC_STAGES)) u_cpu_t (
        .clk_src_i (clk_cpu_i), .rst_n_i (rst_n),
        .stop_req_i(~en_cpu_i), .clk_o (cpu_t_lane)
    );
    ckstop_lane #(.SYNC_STAGES(SYNC_STAGES)) u_cpu_c (
        .clk_src_i (clk_cpu_n), .rst_n_i (rst_n),
        .stop_req_i(~en_cpu_i), .clk_o (cpu_c_lane)
    );

    always_comb begin
        cpu_t_o       = pd_park | cpu_t_lane;
        cpu_c_o       = ~pd_park & cpu_c_lane;
        cpu_c_float_o = pd_park;
    end

    for (genvar i = 0; i < N_PCI; i++) begin : g_pci
        ckstop_lane #(.SYNC_STAGES(SYNC_STAGES)) u_lane (
            .clk_src_i (clk_pci_i), .rst_n_i (rst_n),
            .stop_req_i(pd_park | pci_stop_act | ~en_pci_i[i]),
            .clk_o     (pci_o[i])
        );
    end

    for (genvar i = 0; i < N_PCIF; i++) begin : g_pcif
        ckstop_lane #(.SYNC_STAGES(SYNC_STAGES)) u_lane (
            .clk_src_i (clk_pci_i), .rst_n_i (rst_n),
            .stop_req_i(pd_park | (stop_pcif_i[i] & pci_stop_act) | ~en_pcif_i[i]),
            .clk_o     (pcif_o[i])
        );
    end

    for (genvar i = 0; i < N_66; i++) begin : g_m66
        ckstop_lane #(.SYNC_STAGES(SYNC_STAGES)) u_lane (
            .clk_src_i (clk_66_i), .rst_n_i (rst_n),
            .stop_req_i(pd_park | ~en_66_i[i]),
            .clk_o     (m66_o[i])
        );
    end

    for (genvar i = 0; i < N_48; i++) begin : g_m48
        ckstop_lane #(.SYNC_STAGES(SYNC_STAGES)) u_lane (
            .clk_src_i (clk_48_i), .rst_n_i (rst_n),
            .stop_req_i(pd_park | ~en_48_i[i]),
            .clk_o     (m48_o[i])
        );
    end

    ckstop_lane #(.SYNC_STAGES(SYNC_STAGES)) u_ref (
        .clk_src_i (clk_ref_i), .rst_n_i (rst_n),
        .stop_req_i(pd_park | ~en_ref_i),
        .clk_o     (ref_o)
    );

    // R6
    park_pair_chk: assert property (@(posedge clk_cpu_i) disable iff (!rst_n)
        pd_park |-> (cpu_t_o && !cpu_c_o && cpu_c_float_o));
    // R6
    float_idle_chk: assert property (@(posedge clk_cpu_i) disable iff (!rst_n)
        !pd_park |-> !cpu_c_float_o);
endmodule

// File: tb/ckstop_ctrl_bench.sv
`timescale 1ns/1ps
module ckstop_ctrl_bench;
    localparam int NOUT     = 19;
    localparam int EXP_LOW  = 0;
    localparam int EXP_RUN  = 1;
    localparam int EXP_HIGH = 2;
    localparam realtime SETTLE = 600.0;
    localparam realtime WIN    = 600.0;

    typedef struct {
        int    idx;
        int    exp;
        string req;
    } item_t;

    logic clk_cpu = 0, clk_pci = 0, clk_66 = 0, clk_48 = 0, clk_ref = 0;
    logic rst_n = 0;
    logic pci_stop_n = 1, pd_n = 1, sw_run = 1, en_cpu = 1, en_ref = 1;
    logic [6:0] en_pci = '1;
    logic [2:0] en_pcif = '1, stop_pcif = '0;
    logic [3:0] en_66 = '1;
    logic [1:0] en_48 = '1;
    logic pd_model = 0;

    logic cpu_t_o, cpu_c_o, cpu_c_float_o, ref_o;
    logic [6:0] pci_o;
    logic [2:0] pcif_o;
    logic [3:0] m66_o;
    logic [1:0] m48_o;

    always #4  clk_cpu = ~clk_cpu;
    always #12 clk_pci = ~clk_pci;
    always #7  clk_66  = ~clk_66;
    always #10 clk_48  = ~clk_48;
    always #35 clk_ref = ~clk_ref;

    ckstop_ctrl u_ckstop_ctrl (
        .clk_cpu_i(clk_cpu), .clk_pci_i(clk_pci), .clk_66_i(clk_66),
        .clk_48_i(clk_48), .clk_ref_i(clk_ref), .rst_n(rst_n),
        .pci_stop_n_i(pci_stop_n), .pd_n_i(pd_n), .sw_pci_run_i(sw_run),
        .en_cpu_i(en_cpu), .en_pci_i(en_pci), .en_pcif_i(en_pcif),
        .stop_pcif_i(stop_pcif), .en_66_i(en_66), .en_48_i(en_48),
        .en_ref_i(en_ref), .cpu_t_o(cpu_t_o), .cpu_c_o(cpu_c_o),
        .cpu_c_float_o(cpu_c_float_o), .pci_o(pci_o), .pcif_o(pcif_o),
        .m66_o(m66_o), .m48_o(m48_o), .ref_o(ref_o)
    );

    // bit map: 0 cpu_t, 1 cpu_c, 2..8 pci, 9..11 pcif, 12..15 m66, 16..17 m48, 18 ref
    logic [NOUT-1:0] mon_w;
    assign mon_w = {ref_o, m48_o, m66_o, pcif_o, pci_o, cpu_c_o, cpu_t_o};

    int edge_w [NOUT];
    int pulse_w[NOUT];
    int runt_w [NOUT];

    function automatic realtime half_of(int i);
        if (i < 2)       return 4.0;
        else if (i < 12) return 12.0;
        else if (i < 16) return 7.0;
        else if (i < 18) return 10.0;
        else             return 35.0;
    endfunction

    // R8: pulse-width monitor on every output
    for (genvar g = 0; g < NOUT; g++) begin : g_mon
        int edges = 0;
        int pulses = 0;
        int runts = 0;
        realtime t_up = -1.0;
        always @(posedge mon_w[g]) begin
            edges++;
            t_up = $realtime;
        end
        always @(negedge mon_w[g]) begin
            if (t_up >= 0.0) begin
                pulses++;
                if ($realtime - t_up < half_of(g) - 0.01) begin
                    runts++;
                    $display("FAIL R8 output %0d high pulse %0t ns, expected >= %0t ns",
                             g, $realtime - t_up, half_of(g));
                end
            end
        end
        assign edge_w[g]  = edges;
        assign pulse_w[g] = pulses;
        assign runt_w[g]  = runts;
    end

    int errors = 0;
    int checks = 0;
    item_t sb_q[$];
    event win_go, win_done;

    function automatic int exp_of(int i);
        logic stopc;
        stopc = !pci_stop_n || !sw_run;
        if (i == 0) return pd_model ? EXP_HIGH : (en_cpu ? EXP_RUN : EXP_LOW);
        if (i == 1) return pd_model ? EXP_LOW  : (en_cpu ? EXP_RUN : EXP_LOW);
        if (pd_model) return EXP_LOW;
        if (i < 9)  return (en_pci[i-2] && !stopc) ? EXP_RUN : EXP_LOW;
        if (i < 12) return (en_pcif[i-9] && !(stop_pcif[i-9] && stopc)) ? EXP_RUN : EXP_LOW;
        if (i < 16) return en_66[i-12] ? EXP_RUN : EXP_LOW;
        if (i < 18) return en_48[i-16] ? EXP_RUN : EXP_LOW;
        return en_ref ? EXP_RUN : EXP_LOW;
    endfunction

    // driver side: push expectations, then open an observation window
    task automatic check_window(input string req);
        item_t it;
        #(SETTLE);
        checks++;
        if (cpu_c_float_o !== pd_model) begin
            errors++;
            $display("FAIL R6 (%s) float indication actual=%0b expected=%0b",
                     req, cpu_c_float_o, pd_model);
        end
        for (int i = 0; i < NOUT; i++) begin
            it.idx = i;
            it.exp = exp_of(i);
            it.req = req;
            sb_q.push_back(it);
        end
        ->win_go;
        @(win_done);
    endtask

    // monitor side: count edges in the window, pop and compare
    initial begin
        int snap[NOUT];
        forever begin
            @(win_go);
            for (int i = 0; i < NOUT; i++) snap[i] = edge_w[i];
            #(WIN);
            while (sb_q.size() > 0) begin
                item_t it;
                int d;
                logic lvl;
                bit ok;
                it  = sb_q.pop_front();
                d   = edge_w[it.idx] - snap[it.idx];
                lvl = mon_w[it.idx];
                case (it.exp)
                    EXP_RUN:  ok = (d > 0);
                    EXP_HIGH: ok = (d == 0) && (lvl === 1'b1);
                    default:  ok = (d == 0) && (lvl === 1'b0);
                endcase
                checks++;
                if (!ok) begin
                    errors++;
                    $display("FAIL %s output %0d: edges=%0d level=%0b, expected class %0d (0 low,1 run,2 high)",
                             it.req, it.idx, d, lvl, it.exp);
                end
            end
            ->win_done;
        end
    end

    task automatic finish_run();
        for (int i = 0; i < NOUT; i++) begin
            checks += pulse_w[i];
            errors += runt_w[i];
        end
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    initial begin
        #200000;
        errors++;
        checks++;
        $display("FAIL R8 watchdog: actual=timeout expected=completed run");
        finish_run();
    end

    initial begin
        // R9: reset state
        #21;
        for (int i = 0; i < NOUT; i++) begin
            checks++;
            if (mon_w[i] !== 1'b0) begin
                errors++;
                $display("FAIL R9 output %0d in reset actual=%0b expected=0", i, mon_w[i]);
            end
        end
        checks++;
        if (cpu_c_float_o !== 1'b0) begin
            errors++;
            $display("FAIL R9 float in reset actual=%0b expected=0", cpu_c_float_o);
        end
        #30 rst_n = 1;

        check_window("R8 baseline");

        pci_stop_n = 0;                   // R1 pin path, R2 group stop, R3 free lanes run
        check_window("R1,R2,R3 pin");

        stop_pcif = 3'b101;               // R3 mixed stoppable mask
        check_window("R3 mask");

        pci_stop_n = 1; sw_run = 0;       // R1 software path
        check_window("R1,R2 soft");

        sw_run = 1;                       // R8 restart
        check_window("R8 resume");

        en_cpu = 0; en_pci[3] = 0; en_pcif[1] = 0;
        en_66[1] = 0; en_48[0] = 0; en_ref = 0;   // R7
        check_window("R7 disable");
        en_cpu = 1; en_pci = '1; en_pcif = '1; en_66 = '1; en_48 = '1; en_ref = 1;
        check_window("R7,R8 enable");

        @(negedge clk_cpu) pd_n = 0;      // R4: one rising edge sees low
        @(negedge clk_cpu) pd_n = 1;
        check_window("R4 single");

        @(negedge clk_cpu) pd_n = 0;      // R4, R5, R6, R10
        pd_model = 1;
        check_window("R4,R5,R6,R10 down");

        @(negedge clk_cpu) pd_n = 1;      // R8 exit
        pd_model = 0;
        check_window("R8 wake");

        finish_run();
    end
endmodule